// File: doc/BRIEF.md
# Peripheral Register Front End

This block is the face a single peripheral shows to a processor: four 16-bit registers on a simple synchronous bus. The four registers hold data, status, control and one reserved slot. The device behind the registers is modelled as strobes. An input strobe hands in a word. A done strobe says the output side has consumed its word. A set of error strobes report faults. The processor sees the device's progress in the status register. It picks options and interrupt enables in the control register.

The block does not wait for software to poll it. When the matching enable is set, it holds a level interrupt request whenever a transfer could proceed at once: a received word is waiting, or the output side is free for a new word. Faults are latched. They are summarised in bit 15 of the status word, so a faulted status reads as a negative number. Reads are combinational within the bus cycle. Writes and read side effects take effect at the clock edge that ends the cycle.

Top module: `periph_regs`

## Requirements
- R1: After reset, status reads 0x0002 (output side free, nothing received, no faults), control reads 0x0000 and irq is low.
- R2: Address 3 is reserved: writes to it change nothing, and reads of it return 0x0000.
- R3: An input strobe latches devInData and sets status bit 0. A read of address 0 returns the latched word, and that read clears status bit 0.
- R4: A write to address 0 drives the word on devOutData, pulses devOutLoad for exactly one cycle and clears status bit 1. A done strobe sets status bit 1 again.
- R5: Writes to the status register (address 1) have no effect on any status bit.
- R6: Device error strobe line k sets status bit 4+k, which stays set after the strobe ends. Bit 15 is set whenever any error bit (4 through 8) is set.
- R7: An input strobe that arrives while status bit 0 is set, in a cycle with no data read, sets the overrun error bit 8. The newest word replaces the old one.
- R8: Writing control (address 2) with bit 2 set clears all error bits and bit 15. Bit 2 always reads back 0. An error strobe in the same cycle as the clear still gets recorded.
- R9: Control bits other than bit 2 read back as last written.
- R10: irq is high exactly while (control bit 0 and status bit 0) or (control bit 1 and status bit 1).
- R11: A data read in the same cycle as an input strobe returns the old word. After that cycle, status bit 0 is still set, the new word is held, and no overrun is flagged.
- R12: A data write in the same cycle as a done strobe leaves status bit 1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus cycle active |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register index: 0 data, 1 status, 2 control, 3 reserved |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid during a read cycle, else 0 |
| devInValid | input | 1 | Device input strobe |
| devInData | input | 16 | Device input word |
| devOutDone | input | 1 | Device has consumed the output word |
| devErr | input | NUM_DEV_ERR | Device error strobes |
| devOutData | output | 16 | Word for the device |
| devOutLoad | output | 1 | One-cycle pulse when devOutData is new |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the same-cycle collisions. In the first, a read meets a new input word. A design that gave priority to the read would lose the ready flag or raise a false overrun. In the second, a write meets a done strobe. Here the wrong priority leaves the output side marked free while a word is still pending. In the third, a clear meets a new error, and the wrong priority would silently drop the fault. The bench also writes all ones to the status and reserved slots and reads back a complement-free result. It then checks that the interrupt follows the ready levels and falls as soon as a read or write removes the condition.

// File: rtl/periph_regs_pkg.sv
package periph_regs_pkg;
  localparam int REG_W = 16;

  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_EXTRA = 2'd3;

  localparam int ST_IN_RDY  = 0;
  localparam int ST_OUT_RDY = 1;
  localparam int ST_ERR_LSB = 4;
  localparam int ST_SUMMARY = 15;

  localparam int CT_IN_IE   = 0;
  localparam int CT_OUT_IE  = 1;
  localparam int CT_CLR_ERR = 2;

  typedef struct packed {
    logic rdData;
    logic wrData;
    logic wrCtrl;
    logic rdAny;
  } busStrobes_t;
endpackage

// File: rtl/periph_regs_ctrl.sv
module periph_regs_ctrl
  import periph_regs_pkg::*;
(
  input  logic        busSel,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  output busStrobes_t stb
);
  always_comb begin
    stb.rdAny  = busSel && !busWr;
    stb.rdData = busSel && !busWr && (busAddr == ADDR_DATA);
    stb.wrData = busSel &&  busWr && (busAddr == ADDR_DATA);
    stb.wrCtrl = busSel &&  busWr && (busAddr == ADDR_CTRL);
  end
endmodule

// File: rtl/periph_regs_dp.sv
module periph_regs_dp
  import periph_regs_pkg::*;
#(
  parameter int NUM_DEV_ERR = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  busStrobes_t            stb,
  input  logic [1:0]             busAddr,
  input  logic [REG_W-1:0]       busWdata,
  output logic [REG_W-1:0]       busRdata,
  input  logic                   devInValid,
  input  logic [REG_W-1:0]       devInData,
  input  logic                   devOutDone,
  input  logic [NUM_DEV_ERR-1:0] devErr,
  output logic [REG_W-1:0]       devOutData,
  output logic                   devOutLoad,
  output logic                   irq,
  output logic [REG_W-1:0]       statusW,
  output logic [REG_W-1:0]       ctrlW
);
  localparam int OVR_BIT = ST_ERR_LSB + NUM_DEV_ERR;

  logic [REG_W-1:0]       inReg, outReg, ctrlQ;
  logic                   inReady, outReady, ovrQ, outLoadQ;
  logic [NUM_DEV_ERR-1:0] errQ, errNext;
  logic                   ovrNext, clrErr;

  always_comb begin
    clrErr  = stb.wrCtrl && busWdata[CT_CLR_ERR];
    errNext = (clrErr ? '0 : errQ) | devErr;
    ovrNext = (clrErr ? 1'b0 : ovrQ) | (devInValid && inReady && !stb.rdData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg    <= '0;
      outReg   <= '0;
      ctrlQ    <= '0;
      inReady  <= 1'b0;
      outReady <= 1'b1;
      errQ     <= '0;
      ovrQ     <= 1'b0;
      outLoadQ <= 1'b0;
    end else begin
      errQ     <= errNext;
      ovrQ     <= ovrNext;
      outLoadQ <= stb.wrData;
      if (devInValid) begin
        inReg   <= devInData;
        inReady <= 1'b1;
      end else if (stb.rdData) begin
        inReady <= 1'b0;
      end
      if (stb.wrData) begin
        outReg   <= busWdata;
        outReady <= 1'b0;
      end else if (devOutDone) begin
        outReady <= 1'b1;
      end
      if (stb.wrCtrl) begin
        ctrlQ             <= busWdata;
        ctrlQ[CT_CLR_ERR] <= 1'b0;
      end
    end
  end

  always_comb begin
    statusW             = '0;
    statusW[ST_IN_RDY]  = inReady;
    statusW[ST_OUT_RDY] = outReady;
    for (int k = 0; k < NUM_DEV_ERR; k++) statusW[ST_ERR_LSB + k] = errQ[k];
    statusW[OVR_BIT]    = ovrQ;
    statusW[ST_SUMMARY] = (|errQ) | ovrQ;
  end

  always_comb begin
    busRdata = '0;
    if (stb.rdAny) begin
      case (busAddr)
        ADDR_DATA: busRdata = inReg;
        ADDR_STAT: busRdata = statusW;
        ADDR_CTRL: busRdata = ctrlQ;
        default:   busRdata = '0;
      endcase
    end
  end

  assign ctrlW      = ctrlQ;
  assign devOutData = outReg;
  assign devOutLoad = outLoadQ;
  assign irq        = (ctrlQ[CT_IN_IE] && inReady) || (ctrlQ[CT_OUT_IE] && outReady);
endmodule

// File: rtl/periph_regs.sv
module periph_regs
  import periph_regs_pkg::*;
#(
  parameter int NUM_DEV_ERR = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWr,
  input  logic [1:0]             busAddr,
  input  logic [REG_W-1:0]       busWdata,
  output logic [REG_W-1:0]       busRdata,
  input  logic                   devInValid,
  input  logic [REG_W-1:0]       devInData,
  input  logic                   devOutDone,
  input  logic [NUM_DEV_ERR-1:0] devErr,
  output logic [REG_W-1:0]       devOutData,
  output logic                   devOutLoad,
  output logic                   irq
);
  busStrobes_t      stb;
  logic [REG_W-1:0] statusW, ctrlW;

  periph_regs_ctrl ctrl_i (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  periph_regs_dp #(.NUM_DEV_ERR(NUM_DEV_ERR)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .devInValid(devInValid),
    .devInData (devInData),
    .devOutDone(devOutDone),
    .devErr    (devErr),
    .devOutData(devOutData),
    .devOutLoad(devOutLoad),
    .irq       (irq),
    .statusW   (statusW),
    .ctrlW     (ctrlW)
  );
endmodule

// File: rtl/periph_regs_chk.sv
module periph_regs_chk
  import periph_regs_pkg::*;
#(
  parameter int NUM_DEV_ERR = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busSel,
  input logic                   busWr,
  input logic [1:0]             busAddr,
  input logic [REG_W-1:0]       busWdata,
  input logic [REG_W-1:0]       busRdata,
  input logic                   devInValid,
  input logic [NUM_DEV_ERR-1:0] devErr,
  input logic                   devOutLoad,
  input logic                   irq,
  input logic [REG_W-1:0]       statusW,
  input logic [REG_W-1:0]       ctrlW
);
  // R2
  extra_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == ADDR_EXTRA) |-> (busRdata == '0));

  // R3
  input_sets_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    devInValid |=> statusW[ST_IN_RDY]);

  // R4
  out_write_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_DATA) |=> (devOutLoad && !statusW[ST_OUT_RDY]));

  // R6
  err_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devErr != '0) |=> statusW[ST_SUMMARY]);

  // R8
  clear_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_CTRL && busWdata[CT_CLR_ERR] &&
     devErr == '0 && !devInValid) |=> !statusW[ST_SUMMARY]);

  // R8
  clr_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlW[CT_CLR_ERR]);

  // R10
  irq_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlW[CT_IN_IE] && !ctrlW[CT_OUT_IE]) |-> !irq);
endmodule

bind periph_regs periph_regs_chk #(.NUM_DEV_ERR(NUM_DEV_ERR)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .devInValid(devInValid),
  .devErr    (devErr),
  .devOutLoad(devOutLoad),
  .irq       (irq),
  .statusW   (statusW),
  .ctrlW     (ctrlW)
);

// File: tb/periph_regs_tb_top.sv
module periph_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NERR = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        devInValid = 1'b0;
  logic [15:0] devInData = '0;
  logic        devOutDone = 1'b0;
  logic [NERR-1:0] devErr = '0;
  logic [15:0] devOutData;
  logic        devOutLoad, irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_regs #(.NUM_DEV_ERR(NERR)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .devInValid(devInValid),
    .devInData(devInData), .devOutDone(devOutDone), .devErr(devErr),
    .devOutData(devOutData), .devOutLoad(devOutLoad), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic pulseIn(input logic [15:0] d);
    @(negedge clk);
    devInValid = 1'b1; devInData = d;
    @(negedge clk);
    devInValid = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    devOutDone = 1'b1;
    @(negedge clk);
    devOutDone = 1'b0;
  endtask

  task automatic pulseErr(input logic [NERR-1:0] e);
    @(negedge clk);
    devErr = e;
    @(negedge clk);
    devErr = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    busRead(2'd1, v); chk("R1 status", v, 16'h0002);
    busRead(2'd2, v); chk("R1 control", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_extra();
    logic [15:0] v;
    busWrite(2'd3, 16'hFFFF);
    busRead(2'd3, v); chk("R2 extra read", v, 16'h0000);
    busRead(2'd1, v); chk("R2 status untouched", v, 16'h0002);
    busRead(2'd2, v); chk("R2 control untouched", v, 16'h0000);
  endtask

  task automatic t_statusWrite();
    logic [15:0] v;
    busWrite(2'd1, 16'hFFFF);
    busRead(2'd1, v); chk("R5 status write ignored", v, 16'h0002);
  endtask

  task automatic t_input();
    logic [15:0] v;
    pulseIn(16'h1234);
    busRead(2'd1, v); chk("R3 ready set", v, 16'h0003);
    busRead(2'd0, v); chk("R3 data", v, 16'h1234);
    busRead(2'd1, v); chk("R3 ready cleared", v, 16'h0002);
  endtask

  task automatic t_output();
    logic [15:0] v;
    busWrite(2'd0, 16'hBEEF);
    chk("R4 load pulse", {15'd0, devOutLoad}, 16'h0001);
    chk("R4 out data", devOutData, 16'hBEEF);
    @(negedge clk);
    chk("R4 load one cycle", {15'd0, devOutLoad}, 16'h0000);
    busRead(2'd1, v); chk("R4 out busy", v, 16'h0000);
    pulseDone();
    busRead(2'd1, v); chk("R4 out free again", v, 16'h0002);
  endtask

  task automatic t_ctrl();
    logic [15:0] v;
    busWrite(2'd2, 16'hA5A4);
    busRead(2'd2, v); chk("R9 ctrl readback, R8 clr bit reads 0", v, 16'hA5A0);
    busWrite(2'd2, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    busWrite(2'd2, 16'h0002);
    chk("R10 irq out ready", {15'd0, irq}, 16'h0001);
    busWrite(2'd0, 16'h0055);
    chk("R10 irq drops on write", {15'd0, irq}, 16'h0000);
    pulseDone();
    busWrite(2'd2, 16'h0001);
    chk("R10 irq in idle", {15'd0, irq}, 16'h0000);
    pulseIn(16'h0F0F);
    chk("R10 irq in ready", {15'd0, irq}, 16'h0001);
    busRead(2'd0, v);
    chk("R10 irq drops on read", {15'd0, irq}, 16'h0000);
    busWrite(2'd2, 16'h0000);
  endtask

  task automatic t_errors();
    logic [15:0] v;
    pulseErr(4'b0100);
    busRead(2'd1, v); chk("R6 err bit6 and summary", v, 16'h8042);
    pulseErr(4'b0001);
    repeat (3) @(negedge clk);
    busRead(2'd1, v); chk("R6 sticky errors", v, 16'h8052);
    busWrite(2'd2, 16'h0004);
    busRead(2'd1, v); chk("R8 clear", v, 16'h0002);
    @(negedge clk);
    devErr = 4'b0001;
    busSel = 1'b1; busWr = 1'b1; busAddr = 2'd2; busWdata = 16'h0004;
    @(negedge clk);
    devErr = '0; busSel = 1'b0; busWr = 1'b0;
    busRead(2'd1, v); chk("R8 error wins over clear", v, 16'h8012);
    busWrite(2'd2, 16'h0004);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    pulseIn(16'h1111);
    pulseIn(16'h2222);
    busRead(2'd1, v); chk("R7 overrun flag", v, 16'h8103);
    busRead(2'd0, v); chk("R7 newest word kept", v, 16'h2222);
    busWrite(2'd2, 16'h0004);
    busRead(2'd1, v); chk("R7 overrun cleared", v, 16'h0002);
  endtask

  task automatic t_readCollide();
    logic [15:0] v;
    pulseIn(16'h3333);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 2'd0;
    devInValid = 1'b1; devInData = 16'h4444;
    #1 v = busRdata;
    @(negedge clk);
    busSel = 1'b0; devInValid = 1'b0;
    chk("R11 old word returned", v, 16'h3333);
    busRead(2'd1, v); chk("R11 ready kept, no overrun", v, 16'h0003);
    busRead(2'd0, v); chk("R11 new word held", v, 16'h4444);
  endtask

  task automatic t_writeCollide();
    logic [15:0] v;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 2'd0; busWdata = 16'h7777;
    devOutDone = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; devOutDone = 1'b0;
    busRead(2'd1, v); chk("R12 write beats done", v, 16'h0000);
    pulseDone();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_extra();
    t_statusWrite();
    t_input();
    t_output();
    t_ctrl();
    t_irq();
    t_errors();
    t_overrun();
    t_readCollide();
    t_writeCollide();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule